// File: doc/BRIEF.md
# Load/Store Microop Execute Stage

This block executes one memory-class microop at a time. An operation is described by its kind, a scale factor, index and base register values, a displacement, a segment base, an operand size, an address size, the old value of the destination register, and flag bits. From these it forms an effective address. It then issues a single request with attribute bits on a valid/ready memory port and waits for the response on a second valid/ready port. It ends the operation with a one-cycle completion pulse that carries the fault outcome and, where the operation writes a register, the merged writeback value.

Loads narrower than four bytes splice into the old register contents. Loads of four or more bytes zero-fill the upper part. The address-only kind skips the segment base and the memory port entirely and returns the truncated address through the same merge path. Store kinds send size-trimmed data. The line-check kind sends zero data and marks the request as touching no bytes. Operations with unsupported size encodings are rejected without any memory traffic.

Top module: `memop_exec`

## Requirements
- R1: For memory kinds, `mreq_addr` equals segment base + scale × index + base + displacement, kept to its low 8 × address-size bits. Supported address sizes are 2, 4 and 8 bytes.
- R2: The address-only kind (`op_kind` 6) leaves out the segment base but applies the same truncation. It raises no request. One cycle after acceptance it pulses `done` with `wb_en` = 1, and `wb_data` holds the address merged by the R3/R4 rule.
- R3: With operand size 1 or 2 bytes, `wb_data` takes its low size bytes from the new value and keeps every higher bit of `op_dest_old`.
- R4: With operand size 4 or 8 bytes, `wb_data` is the new value masked to size bytes, with all higher bits zero.
- R5: The prefetch flag affects only load kinds 0–2. If a prefetch load's response has `mrsp_fault` = 1, the completion shows `done_fault` = 0 and `wb_en` = 0.
- R6: If a non-prefetch load's response has `mrsp_fault` = 1, the completion shows `done_fault` = 1 and `wb_en` = 0. A load without a fault shows `wb_en` = 1.
- R7: Store kinds 3 and 4 issue `mreq_write` = 1 with `mreq_wdata` set to the low size bytes of `op_store_data` and the rest zero. `done_fault` copies the response fault, and `wb_en` stays 0.
- R8: `mreq_attr` bit 0 (lock) is set for kinds 2 and 4 only. Bit 1 (store-check) is set for kinds 1 and 2 only. Bit 5 (prefetch) is set only for load kinds 0–2 that carry the prefetch flag.
- R9: The line-check kind 5 issues `mreq_write` = 1 with `mreq_wdata` = 0 and `mreq_attr` bit 2 (no-access) set. Bit 2 is never set for any other kind.
- R10: `mreq_attr` bit 3 follows `op_cpl0`, and bit 4 follows `op_addr_ovr`.
- R11: An operation is illegal when its kind is 7, its operand size is not 1, 2, 4 or 8, or its address size is not 2, 4 or 8. An illegal operation raises no request. One cycle after acceptance it pulses `done` with `done_illegal` = 1 and `wb_en` = 0.
- R12: `op_ready` is low from acceptance of a memory kind until the response handshake. The request holds valid and stable until `mreq_ready`. `done` is high for exactly the one cycle after the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Stage idle, operation accepted this cycle |
| op_kind | input | 3 | 0 load, 1 load+store-check, 2 locked load+store-check, 3 store, 4 locked store, 5 line check, 6 address only |
| op_scale | input | 4 | Index multiplier |
| op_index | input | XLEN | Index register value |
| op_base | input | XLEN | Base register value |
| op_disp | input | XLEN | Displacement |
| op_segbase | input | XLEN | Segment base |
| op_dsize | input | 4 | Operand size in bytes |
| op_asize | input | 4 | Address size in bytes |
| op_dest_old | input | XLEN | Current destination value |
| op_store_data | input | XLEN | Store source value |
| op_cpl0 | input | 1 | Run at privileged level |
| op_addr_ovr | input | 1 | Legacy address-size prefix present |
| op_prefetch | input | 1 | Prefetch flag |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request taken |
| mreq_addr | output | XLEN | Request address |
| mreq_write | output | 1 | Request is a write |
| mreq_wdata | output | XLEN | Write data |
| mreq_size | output | 4 | Access size in bytes |
| mreq_attr | output | 6 | Attribute bits (see R8–R10) |
| mrsp_valid | input | 1 | Response valid |
| mrsp_ready | output | 1 | Response taken |
| mrsp_data | input | XLEN | Read data |
| mrsp_fault | input | 1 | Access faulted |
| done | output | 1 | Operation complete pulse |
| done_fault | output | 1 | Reported fault |
| done_illegal | output | 1 | Illegal encoding |
| wb_en | output | 1 | Destination write enable |
| wb_data | output | XLEN | Destination value |

## Verification
The bench sweeps every kind against all operand sizes, address sizes and scales. It checks the 2/4 boundary of the merge rule, where a design with the rule flipped would either zero the upper bits of a byte load or keep stale bits above a dword load. Prefetch and non-prefetch loads are driven with faulting responses. This catches a design that leaks a prefetch fault or writes back a faulted value. The bench also catches an address-only operation that adds the segment base or touches memory, and a line check that sends real data. Requests are held unready for several cycles to expose a request that drifts or drops before its handshake.

// File: rtl/memop_exec.sv
module memop_exec #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [2:0]      op_kind,
  input  logic [3:0]      op_scale,
  input  logic [XLEN-1:0] op_index,
  input  logic [XLEN-1:0] op_base,
  input  logic [XLEN-1:0] op_disp,
  input  logic [XLEN-1:0] op_segbase,
  input  logic [3:0]      op_dsize,
  input  logic [3:0]      op_asize,
  input  logic [XLEN-1:0] op_dest_old,
  input  logic [XLEN-1:0] op_store_data,
  input  logic            op_cpl0,
  input  logic            op_addr_ovr,
  input  logic            op_prefetch,
  output logic            mreq_valid,
  input  logic            mreq_ready,
  output logic [XLEN-1:0] mreq_addr,
  output logic            mreq_write,
  output logic [XLEN-1:0] mreq_wdata,
  output logic [3:0]      mreq_size,
  output logic [5:0]      mreq_attr,
  input  logic            mrsp_valid,
  output logic            mrsp_ready,
  input  logic [XLEN-1:0] mrsp_data,
  input  logic            mrsp_fault,
  output logic            done,
  output logic            done_fault,
  output logic            done_illegal,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_data
);
  localparam logic [2:0] K_LD = 3'd0, K_LDSC = 3'd1, K_LDLK = 3'd2, K_ST = 3'd3,
                         K_STLK = 3'd4, K_LINE = 3'd5, K_ADDR = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_t;
  state_t state;

  function automatic logic [XLEN-1:0] byte_mask(input logic [3:0] n);
    byte_mask = ~({XLEN{1'b1}} << (8 * n));
  endfunction

  function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old_v,
                                            input logic [XLEN-1:0] new_v,
                                            input logic [3:0] n);
    logic [XLEN-1:0] m;
    m = byte_mask(n);
    merge = (n < 4'd4) ? ((old_v & ~m) | (new_v & m)) : (new_v & m);
  endfunction

  logic is_load, is_store_like, legal, accept;
  logic [XLEN-1:0] ea_sum, ea_new;
  logic [2:0]      kind_q;
  logic [3:0]      dsize_q;
  logic [XLEN-1:0] dest_q, addr_q, wdata_q;
  logic            pf_q, write_q;
  logic [5:0]      attr_q;

  assign is_load       = (op_kind == K_LD) || (op_kind == K_LDSC) || (op_kind == K_LDLK);
  assign is_store_like = (op_kind == K_ST) || (op_kind == K_STLK) || (op_kind == K_LINE);
  assign legal = (op_kind != 3'd7) &&
                 (op_dsize == 4'd1 || op_dsize == 4'd2 || op_dsize == 4'd4 || op_dsize == 4'd8) &&
                 (op_asize == 4'd2 || op_asize == 4'd4 || op_asize == 4'd8) &&
                 (32'(op_dsize) * 8 <= XLEN) && (32'(op_asize) * 8 <= XLEN);
  assign ea_sum = ((op_kind == K_ADDR) ? '0 : op_segbase) + XLEN'(op_scale) * op_index
                  + op_base + op_disp;
  assign ea_new = ea_sum & byte_mask(op_asize);
  assign accept = op_valid && (state == S_IDLE);

  assign op_ready   = (state == S_IDLE);
  assign mreq_valid = (state == S_REQ);
  assign mrsp_ready = (state == S_RSP);
  assign mreq_addr  = addr_q;
  assign mreq_write = write_q;
  assign mreq_wdata = wdata_q;
  assign mreq_size  = dsize_q;
  assign mreq_attr  = attr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      kind_q <= '0; dsize_q <= '0; dest_q <= '0; addr_q <= '0; wdata_q <= '0;
      pf_q <= 1'b0; write_q <= 1'b0; attr_q <= '0;
      done <= 1'b0; done_fault <= 1'b0; done_illegal <= 1'b0;
      wb_en <= 1'b0; wb_data <= '0;
    end else begin
      done <= 1'b0; done_fault <= 1'b0; done_illegal <= 1'b0; wb_en <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          kind_q  <= op_kind;
          dsize_q <= op_dsize;
          dest_q  <= op_dest_old;
          addr_q  <= ea_new;
          pf_q    <= op_prefetch && is_load;
          write_q <= is_store_like;
          wdata_q <= (op_kind == K_LINE || !is_store_like) ? '0
                     : (op_store_data & byte_mask(op_dsize));
          attr_q  <= {op_prefetch && is_load, op_addr_ovr, op_cpl0, op_kind == K_LINE,
                      op_kind == K_LDSC || op_kind == K_LDLK,
                      op_kind == K_LDLK || op_kind == K_STLK};
          if (!legal) begin
            done <= 1'b1;
            done_illegal <= 1'b1;
          end else if (op_kind == K_ADDR) begin
            done <= 1'b1;
            wb_en <= 1'b1;
            wb_data <= merge(op_dest_old, ea_new, op_dsize);
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ: if (mreq_ready) state <= S_RSP;
        S_RSP: if (mrsp_valid) begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (write_q) begin
            done_fault <= mrsp_fault;
          end else begin
            done_fault <= mrsp_fault && !pf_q;
            wb_en      <= !mrsp_fault;
            if (!mrsp_fault) wb_data <= merge(dest_q, mrsp_data, dsize_q);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) &&
                                  $stable(mreq_wdata) && $stable(mreq_attr));
  p_done_after_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_valid && mrsp_ready |=> done);
  p_fault_blocks_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && (done_fault || done_illegal) |-> !wb_en);
  p_noaccess_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_attr[2] |-> mreq_write && (mreq_wdata == '0));
  p_addr_only_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> kind_q != K_ADDR);
  p_wb_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
endmodule

// File: tb/memop_exec_test.sv
module memop_exec_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        op_valid = 0, op_ready;
  logic [2:0]  op_kind = 0;
  logic [3:0]  op_scale = 0, op_dsize = 0, op_asize = 0;
  logic [63:0] op_index = 0, op_base = 0, op_disp = 0, op_segbase = 0, op_dest_old = 0, op_store_data = 0;
  logic        op_cpl0 = 0, op_addr_ovr = 0, op_prefetch = 0;
  logic        mreq_valid, mreq_ready = 0, mreq_write;
  logic [63:0] mreq_addr, mreq_wdata;
  logic [3:0]  mreq_size;
  logic [5:0]  mreq_attr;
  logic        mrsp_valid = 0, mrsp_ready, mrsp_fault = 0;
  logic [63:0] mrsp_data = 0;
  logic        done, done_fault, done_illegal, wb_en;
  logic [63:0] wb_data;

  memop_exec #(.XLEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
    .op_scale(op_scale), .op_index(op_index), .op_base(op_base), .op_disp(op_disp),
    .op_segbase(op_segbase), .op_dsize(op_dsize), .op_asize(op_asize),
    .op_dest_old(op_dest_old), .op_store_data(op_store_data), .op_cpl0(op_cpl0),
    .op_addr_ovr(op_addr_ovr), .op_prefetch(op_prefetch), .mreq_valid(mreq_valid),
    .mreq_ready(mreq_ready), .mreq_addr(mreq_addr), .mreq_write(mreq_write),
    .mreq_wdata(mreq_wdata), .mreq_size(mreq_size), .mreq_attr(mreq_attr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .mrsp_fault(mrsp_fault), .done(done), .done_fault(done_fault),
    .done_illegal(done_illegal), .wb_en(wb_en), .wb_data(wb_data));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] low_bytes(input logic [63:0] v, input int n);
    if (n >= 8) return v;
    return v % (64'd1 << (8 * n));
  endfunction

  function automatic logic [63:0] exp_merge(input logic [63:0] old_v, input logic [63:0] new_v, input int n);
    if (n < 4) return ((old_v >> (8 * n)) << (8 * n)) | low_bytes(new_v, n);
    return low_bytes(new_v, n);
  endfunction

  task automatic run_op(input int kind, input int ds, input int as, input int sc,
                        input bit cpl0, input bit aovr, input bit pf, input bit flt, input int dly);
    logic [63:0] seg, idx, bas, dsp, old_v, sdat, rdat, ea, first_addr;
    bit is_ld, legal;
    logic [5:0] exp_attr;
    seg = {$urandom, $urandom}; idx = {$urandom, $urandom}; bas = {$urandom, $urandom};
    dsp = {$urandom, $urandom}; old_v = {$urandom, $urandom}; sdat = {$urandom, $urandom};
    rdat = {$urandom, $urandom};
    is_ld = (kind <= 2);
    legal = (kind != 7) && (ds == 1 || ds == 2 || ds == 4 || ds == 8) && (as == 2 || as == 4 || as == 8);
    ea = low_bytes(((kind == 6) ? 64'd0 : seg) + 64'(sc) * idx + bas + dsp, as);
    exp_attr = {pf && is_ld, aovr, cpl0, kind == 5, kind == 1 || kind == 2, kind == 2 || kind == 4};
    @(negedge clk);
    op_valid = 1; op_kind = 3'(kind); op_scale = 4'(sc); op_index = idx; op_base = bas;
    op_disp = dsp; op_segbase = seg; op_dsize = 4'(ds); op_asize = 4'(as);
    op_dest_old = old_v; op_store_data = sdat; op_cpl0 = cpl0; op_addr_ovr = aovr; op_prefetch = pf;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0;
    if (!legal) begin
      chk(done && done_illegal && !wb_en && !mreq_valid, "R11 illegal completion",
          {mreq_valid, done, done_illegal, wb_en}, 64'b0110);
      return;
    end
    if (kind == 6) begin
      chk(done && wb_en && !mreq_valid && !done_illegal, "R2 address-only completion",
          {mreq_valid, done, wb_en}, 64'b011);
      chk(wb_data == exp_merge(old_v, ea, ds), ds < 4 ? "R2 R3 address merge" : "R2 R4 address fill",
          wb_data, exp_merge(old_v, ea, ds));
      return;
    end
    chk(mreq_valid && !op_ready && !done, "R12 busy with request", {mreq_valid, op_ready, done}, 64'b100);
    chk(mreq_addr == ea, "R1 effective address", mreq_addr, ea);
    chk(mreq_attr == exp_attr, "R8 R9 R10 attributes", 64'(mreq_attr), 64'(exp_attr));
    chk(mreq_write == (kind >= 3), "R7 write flag", 64'(mreq_write), 64'(kind >= 3));
    if (kind == 5) chk(mreq_wdata == 64'd0, "R9 line check data", mreq_wdata, 64'd0);
    else if (kind >= 3) chk(mreq_wdata == low_bytes(sdat, ds), "R7 store data", mreq_wdata, low_bytes(sdat, ds));
    first_addr = mreq_addr;
    for (int i = 0; i < dly; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(mreq_valid && mreq_addr == first_addr && !op_ready, "R12 request held", mreq_addr, first_addr);
    end
    mreq_ready = 1;
    @(posedge clk);
    @(negedge clk);
    mreq_ready = 0;
    chk(!mreq_valid && mrsp_ready && !done, "R12 awaiting response", {mreq_valid, mrsp_ready, done}, 64'b010);
    mrsp_valid = 1; mrsp_data = rdat; mrsp_fault = flt;
    @(posedge clk);
    @(negedge clk);
    mrsp_valid = 0; mrsp_fault = 0;
    chk(done && op_ready, "R12 done after response", {done, op_ready}, 64'b11);
    if (is_ld) begin
      if (flt && pf) chk(!done_fault && !wb_en, "R5 prefetch fault dropped", {done_fault, wb_en}, 64'b00);
      else if (flt) chk(done_fault && !wb_en, "R6 load fault", {done_fault, wb_en}, 64'b10);
      else begin
        chk(!done_fault && wb_en, "R6 load clean", {done_fault, wb_en}, 64'b01);
        chk(wb_data == exp_merge(old_v, rdat, ds), ds < 4 ? "R3 narrow merge" : "R4 wide zero-fill",
            wb_data, exp_merge(old_v, rdat, ds));
      end
    end else begin
      chk(done_fault == flt && !wb_en, "R7 store completion", {done_fault, wb_en}, {flt, 1'b0});
    end
    @(negedge clk);
    chk(!done, "R12 single-cycle done", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int sizes[4] = '{1, 2, 4, 8};
    int asz[3]   = '{2, 4, 8};
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(op_ready && !mreq_valid && !done && !wb_en, "R12 reset state",
        {op_ready, mreq_valid, done, wb_en}, 64'b1000);
    rst_n = 1;
    for (int k = 0; k <= 6; k++)
      for (int d = 0; d < 4; d++)
        for (int a = 0; a < 3; a++)
          for (int s = 0; s < 4; s++)
            run_op(k, sizes[d], asz[a], sizes[s], s[0], s[1], k == 0 || k == 3, 1'b0, (d + s) % 3);
    for (int k = 0; k <= 4; k++)
      for (int d = 0; d < 4; d++) begin
        run_op(k, sizes[d], 8, 2, 1'b0, 1'b0, 1'b1, 1'b1, 1);
        run_op(k, sizes[d], 4, 4, 1'b1, 1'b1, 1'b0, 1'b1, 0);
      end
    run_op(7, 4, 4, 1, 0, 0, 0, 0, 0);
    run_op(0, 3, 4, 1, 0, 0, 0, 0, 0);
    run_op(3, 16, 8, 1, 0, 0, 0, 0, 0);
    run_op(0, 4, 1, 1, 0, 0, 0, 0, 0);
    run_op(6, 4, 6, 1, 0, 0, 0, 0, 0);
    run_op(2, 2, 2, 8, 1, 0, 0, 0, 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule